// File: doc/BRIEF.md
# Minimal Accumulator Stored-Program Core

This block is a very small stored-program processor. It holds a 32-word by 32-bit store, a signed 32-bit accumulator and a 5-bit current-instruction counter. Each executed instruction follows the same order. First the counter steps forward by one, modulo 32. Then the word at the new counter value is fetched and executed. Because of this order, a program placed from address 1 onwards runs first after reset, and a jump to value k continues at address k+1. All control flow is indirect: the jump target or offset is taken from a store word, not from the instruction itself. Arithmetic is limited to loading the negation of a word and subtracting a word. A conditional skip, taken when the accumulator is negative, provides branching.

The core comes out of reset halted. A test environment uses the debug port while the core is halted to fill or inspect the store. It then starts the core with the run input, which executes one instruction per clock, or with the step input, which executes exactly one instruction. Execution stops on the halt opcode or when an enabled breakpoint address equals the counter before a fetch. The halt cause output reports why the core last stopped.

Top module: `mini_acc_core`

## Requirements
- R1: After reset the counter and the accumulator are zero, `halted_o` is 1 and `halt_cause_o` is 0 (0 none, 1 halt opcode, 2 breakpoint, 3 single step).
- R2: For each executed instruction, the counter is first set to (counter+1) mod 32 and the word at that address is executed. The opcode is bits [15:13] and the operand address is bits [4:0]. All other bits are ignored.
- R3: Opcode 0 loads the counter with bits [4:0] of the addressed word, so execution continues at that value plus one.
- R4: Opcode 1 sets the counter to (incremented counter + bits [4:0] of the addressed word) mod 32.
- R5: Opcode 2 loads the accumulator with the two's-complement negation of the addressed word.
- R6: Opcode 3 writes the accumulator into the addressed word. The new value is readable through the debug port.
- R7: Opcodes 4 and 5 both subtract the addressed word from the accumulator, modulo 2^32.
- R8: Opcode 6 adds a further one to the counter (skipping one instruction) only when accumulator bit 31 is set. Its address field has no effect.
- R9: Opcode 7 stops execution. The counter keeps the address of the halt word and the cause becomes 1.
- R10: While running, if `bkpt_en_i` is set and the counter equals `bkpt_addr_i` before a fetch, the core halts with cause 2 and executes nothing that cycle. The first instruction after a start is exempt from this check.
- R11: A pulse on `step_i` while halted executes exactly one instruction and leaves the core halted with cause 3, or cause 1 if that instruction was the halt opcode. If step and run arrive together, step wins.
- R12: A pulse on `run_i` while halted executes one instruction per clock until a halt. While running, the cause reads 0.
- R13: `dbg_rdata_o` always shows the store word at `dbg_addr_i`. A debug write takes effect in the next cycle only when the core is halted and neither run nor step is asserted. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Start continuous execution from halt |
| step_i | input | 1 | Execute one instruction from halt |
| bkpt_en_i | input | 1 | Breakpoint compare enable |
| bkpt_addr_i | input | 5 | Breakpoint counter value |
| dbg_we_i | input | 1 | Debug store write strobe |
| dbg_addr_i | input | 5 | Debug store address |
| dbg_wdata_i | input | 32 | Debug store write data |
| dbg_rdata_o | output | 32 | Store word at the debug address |
| acc_o | output | 32 | Accumulator |
| ci_o | output | 5 | Current-instruction counter |
| halted_o | output | 1 | Core is halted |
| halt_cause_o | output | 2 | Reason for the most recent halt |

## Verification
A straight-line program of negated load, subtract through both subtract codes, and store separates the arithmetic opcodes from one another and from sign mistakes. The skip opcode is run once with a positive accumulator and once with a negative one, and its address field is filled with junk, which exposes both an inverted condition and a decoded address. An absolute jump through a word with junk upper bits, followed by a relative jump whose sum wraps past 31, checks the truncation and the pre-increment ordering. Breakpoints, single steps and debug writes issued during a tight infinite loop show that halting never executes an instruction, that restarting skips the breakpoint once, and that the store is sealed while the core runs.

// File: rtl/macc_pkg.sv
`timescale 1ns/1ps
package macc_pkg;

   typedef enum logic [2:0] {
      OP_JMP_ABS = 3'd0,
      OP_JMP_REL = 3'd1,
      OP_LD_NEG  = 3'd2,
      OP_STORE   = 3'd3,
      OP_SUB     = 3'd4,
      OP_SUB_ALT = 3'd5,
      OP_SKIP_NG = 3'd6,
      OP_HALT    = 3'd7
   } op_e;

   typedef enum logic [1:0] {
      HC_NONE = 2'd0,
      HC_STOP = 2'd1,
      HC_BKPT = 2'd2,
      HC_STEP = 2'd3
   } halt_cause_e;

   localparam int unsigned OPC_W = 3;

endpackage

// File: rtl/macc_store.sv
`timescale 1ns/1ps
module macc_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   output logic [DATA_W-1:0] fetch_data_o,
   input  logic [ADDR_W-1:0] opnd_addr_i,
   output logic [DATA_W-1:0] opnd_data_o,
   input  logic [ADDR_W-1:0] dbg_addr_i,
   output logic [DATA_W-1:0] dbg_data_o
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   generate
      if (DEPTH > 4096) begin : g_bad_depth
         $error("macc_store: depth too large");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_word
         always_ff @(posedge clk) begin
            if (we_i && (waddr_i == ADDR_W'(g))) begin
               words[g] <= wdata_i;
            end
         end
      end
   endgenerate

   assign fetch_data_o = words[fetch_addr_i];
   assign opnd_data_o  = words[opnd_addr_i];
   assign dbg_data_o   = words[dbg_addr_i];

endmodule

// File: rtl/macc_exec.sv
`timescale 1ns/1ps
module macc_exec
   import macc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned OPC_LSB   = 13,
   parameter bit          SUB_ALIAS = 1'b1
) (
   input  logic [ADDR_W-1:0] ci_inc_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] instr_i,
   input  logic [DATA_W-1:0] operand_i,
   output op_e               op_o,
   output logic [ADDR_W-1:0] ea_o,
   output logic [ADDR_W-1:0] ci_next_o,
   output logic [DATA_W-1:0] acc_next_o,
   output logic              st_en_o,
   output logic              halt_o
);
   localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

   logic alt_sub;
   logic unused_instr;

   generate
      if (SUB_ALIAS) begin : g_alias_on
         assign alt_sub = 1'b1;
      end else begin : g_alias_off
         assign alt_sub = 1'b0;
      end
   endgenerate

   assign op_o         = op_e'(instr_i[OPC_LSB +: OPC_W]);
   assign ea_o         = instr_i[ADDR_W-1:0];
   assign unused_instr = ^instr_i;

   always_comb begin
      ci_next_o  = ci_inc_i;
      acc_next_o = acc_i;
      st_en_o    = 1'b0;
      halt_o     = 1'b0;
      unique case (op_o)
         OP_JMP_ABS: ci_next_o  = operand_i[ADDR_W-1:0];
         OP_JMP_REL: ci_next_o  = ci_inc_i + operand_i[ADDR_W-1:0];
         OP_LD_NEG:  acc_next_o = DATA_W'(0) - operand_i;
         OP_STORE:   st_en_o    = 1'b1;
         OP_SUB:     acc_next_o = acc_i - operand_i;
         OP_SUB_ALT: begin
            if (alt_sub) acc_next_o = acc_i - operand_i;
         end
         OP_SKIP_NG: begin
            if (acc_i[DATA_W-1]) ci_next_o = ci_inc_i + ONE_A;
         end
         OP_HALT:    halt_o     = 1'b1;
         default:    halt_o     = 1'b0;
      endcase
   end

endmodule

// File: rtl/macc_ctrl.sv
`timescale 1ns/1ps
module macc_ctrl
   import macc_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              step_i,
   input  logic              bkpt_en_i,
   input  logic [ADDR_W-1:0] bkpt_addr_i,
   input  logic [ADDR_W-1:0] ci_i,
   input  logic              halt_op_i,
   output logic              exec_en_o,
   output logic              dbg_open_o,
   output logic              running_o,
   output halt_cause_e       cause_o
);
   logic        running_q;
   halt_cause_e cause_q;
   logic        start_step, start_run, bkpt_stop;

   assign start_step = !running_q && step_i;
   assign start_run  = !running_q && run_i && !step_i;
   assign bkpt_stop  = running_q && bkpt_en_i && (ci_i == bkpt_addr_i);
   assign exec_en_o  = start_step || start_run || (running_q && !bkpt_stop);
   assign dbg_open_o = !running_q && !run_i && !step_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cause_q   <= HC_NONE;
      end else if (bkpt_stop) begin
         running_q <= 1'b0;
         cause_q   <= HC_BKPT;
      end else if (exec_en_o) begin
         if (halt_op_i) begin
            running_q <= 1'b0;
            cause_q   <= HC_STOP;
         end else if (start_step) begin
            running_q <= 1'b0;
            cause_q   <= HC_STEP;
         end else begin
            running_q <= 1'b1;
            cause_q   <= HC_NONE;
         end
      end
   end

   assign running_o = running_q;
   assign cause_o   = cause_q;

   // R11: a step from halt never leaves the core running
   p_step_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && step_i) |=> !running_q);

   // R10: breakpoint match halts with cause 2
   p_bkpt_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (running_q && bkpt_en_i && ci_i == bkpt_addr_i) |=> (!running_q && cause_q == HC_BKPT));

   // R9: halt opcode stops with cause 1
   p_stop_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en_o && halt_op_i) |=> (!running_q && cause_q == HC_STOP));

endmodule

// File: rtl/mini_acc_core.sv
`timescale 1ns/1ps
module mini_acc_core
   import macc_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned OPC_LSB   = 13,
   parameter bit          SUB_ALIAS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              step_i,
   input  logic              bkpt_en_i,
   input  logic [ADDR_W-1:0] bkpt_addr_i,
   input  logic              dbg_we_i,
   input  logic [ADDR_W-1:0] dbg_addr_i,
   input  logic [DATA_W-1:0] dbg_wdata_i,
   output logic [DATA_W-1:0] dbg_rdata_o,
   output logic [DATA_W-1:0] acc_o,
   output logic [ADDR_W-1:0] ci_o,
   output logic              halted_o,
   output logic [1:0]        halt_cause_o
);
   localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

   generate
      if (DATA_W < OPC_LSB + OPC_W) begin : g_bad_opc
         $error("mini_acc_core: opcode field exceeds word");
      end
      if (ADDR_W > OPC_LSB) begin : g_bad_addr
         $error("mini_acc_core: address field overlaps opcode");
      end
   endgenerate

   logic [ADDR_W-1:0] ci_q, ci_inc, ci_next, ea;
   logic [DATA_W-1:0] acc_q, acc_next, instr, operand;
   logic              st_en, halt_op, exec_en, dbg_open, running;
   logic              st_we;
   logic [ADDR_W-1:0] st_addr;
   logic [DATA_W-1:0] st_data;
   op_e               op;
   halt_cause_e       cause;

   assign ci_inc = ci_q + ONE_A;

   assign st_we   = (exec_en && st_en) || (dbg_open && dbg_we_i);
   assign st_addr = (exec_en && st_en) ? ea    : dbg_addr_i;
   assign st_data = (exec_en && st_en) ? acc_q : dbg_wdata_i;

   macc_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk         (clk),
      .we_i        (st_we),
      .waddr_i     (st_addr),
      .wdata_i     (st_data),
      .fetch_addr_i(ci_inc),
      .fetch_data_o(instr),
      .opnd_addr_i (ea),
      .opnd_data_o (operand),
      .dbg_addr_i  (dbg_addr_i),
      .dbg_data_o  (dbg_rdata_o)
   );

   macc_exec #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_LSB(OPC_LSB),
               .SUB_ALIAS(SUB_ALIAS)) u_exec (
      .ci_inc_i  (ci_inc),
      .acc_i     (acc_q),
      .instr_i   (instr),
      .operand_i (operand),
      .op_o      (op),
      .ea_o      (ea),
      .ci_next_o (ci_next),
      .acc_next_o(acc_next),
      .st_en_o   (st_en),
      .halt_o    (halt_op)
   );

   macc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_i),
      .step_i     (step_i),
      .bkpt_en_i  (bkpt_en_i),
      .bkpt_addr_i(bkpt_addr_i),
      .ci_i       (ci_q),
      .halt_op_i  (halt_op),
      .exec_en_o  (exec_en),
      .dbg_open_o (dbg_open),
      .running_o  (running),
      .cause_o    (cause)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ci_q  <= '0;
         acc_q <= '0;
      end else if (exec_en) begin
         ci_q  <= ci_next;
         acc_q <= acc_next;
      end
   end

   assign acc_o        = acc_q;
   assign ci_o         = ci_q;
   assign halted_o     = !running;
   assign halt_cause_o = cause;

   // R13: no execution means no architectural change
   p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_en |=> ($stable(ci_q) && $stable(acc_q)));

   // R8: taken skip advances the counter by two
   p_skip_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op == OP_SKIP_NG && acc_q[DATA_W-1]) |=> (ci_q == $past(ci_q) + ONE_A + ONE_A));

   // R3: absolute jump takes the low bits of the operand word
   p_jump_abs_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_en && op == OP_JMP_ABS) |=> (ci_q == $past(operand[ADDR_W-1:0])));

endmodule

// File: tb/mini_acc_core_tb_top.sv
`timescale 1ns/1ps
module mini_acc_core_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_i = 1'b0, step_i = 1'b0, bkpt_en_i = 1'b0, dbg_we_i = 1'b0;
   logic [4:0]  bkpt_addr_i = '0, dbg_addr_i = '0;
   logic [31:0] dbg_wdata_i = '0;
   logic [31:0] dbg_rdata_o, acc_o;
   logic [4:0]  ci_o;
   logic        halted_o;
   logic [1:0]  halt_cause_o;

   always #2.5 clk = ~clk;

   mini_acc_core dut_i (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .step_i(step_i),
      .bkpt_en_i(bkpt_en_i), .bkpt_addr_i(bkpt_addr_i),
      .dbg_we_i(dbg_we_i), .dbg_addr_i(dbg_addr_i), .dbg_wdata_i(dbg_wdata_i),
      .dbg_rdata_o(dbg_rdata_o), .acc_o(acc_o), .ci_o(ci_o),
      .halted_o(halted_o), .halt_cause_o(halt_cause_o)
   );

   int    total = 0, bad = 0;
   string cur_req = "R1";
   bit    cmp_on = 1'b0, mem_ok = 1'b0;

   // reference model state
   logic [31:0] m_mem [32];
   logic [31:0] m_acc;
   int          m_ci, m_why;
   bit          m_run;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_step();
      int          pc, a, op;
      logic [31:0] w, v;
      bit          first, halt;
      if (!rst_n) begin
         m_ci = 0; m_acc = '0; m_run = 0; m_why = 0;
         return;
      end
      if (!m_run && !run_i && !step_i) begin
         if (dbg_we_i) m_mem[dbg_addr_i] = dbg_wdata_i;
         return;
      end
      if (m_run && bkpt_en_i && m_ci == int'(bkpt_addr_i)) begin
         m_run = 0; m_why = 2;
         return;
      end
      first = !m_run;
      pc = (m_ci + 1) % 32;
      w  = m_mem[pc];
      op = int'(w[15:13]);
      a  = int'(w[4:0]);
      v  = m_mem[a];
      halt = 0;
      case (op)
         0: pc = int'(v[4:0]);
         1: pc = (pc + int'(v[4:0])) % 32;
         2: m_acc = 32'd0 - v;
         3: m_mem[a] = m_acc;
         4, 5: m_acc = m_acc - v;
         6: if (m_acc[31]) pc = (pc + 1) % 32;
         default: halt = 1;
      endcase
      m_ci = pc;
      if (halt) begin m_run = 0; m_why = 1; end
      else if (first && step_i) begin m_run = 0; m_why = 3; end
      else begin m_run = 1; m_why = 0; end
   endtask

   always @(posedge clk) begin
      model_step();
      #1;
      if (cmp_on) begin
         chk(cur_req, 32'(ci_o), 32'(m_ci), "ci");
         chk(cur_req, acc_o, m_acc, "acc");
         chk(cur_req, 32'(halted_o), 32'(!m_run), "halted");
         chk(cur_req, 32'(halt_cause_o), 32'(m_why), "cause");
         if (mem_ok) chk(cur_req, dbg_rdata_o, m_mem[dbg_addr_i], "dbg_rdata");
      end
   end

   function automatic logic [31:0] ins(int op, int a, logic [31:0] junk);
      return (32'(op) << 13) | 32'(a) | junk;
   endfunction

   task automatic dep(int a, logic [31:0] d);
      dbg_we_i = 1'b1; dbg_addr_i = 5'(a); dbg_wdata_i = d;
      @(negedge clk);
      dbg_we_i = 1'b0;
   endtask

   task automatic wait_halt();
      for (int n = 0; n < 200 && !halted_o; n++) @(negedge clk);
   endtask

   task automatic go_run();
      run_i = 1'b1; @(negedge clk); run_i = 1'b0;
      wait_halt();
   endtask

   task automatic go_step();
      step_i = 1'b1; @(negedge clk); step_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic peek(string req, int a, logic [31:0] exp);
      dbg_addr_i = 5'(a);
      @(negedge clk);
      chk(req, dbg_rdata_o, exp, "store word");
   endtask

   initial begin
      for (int i = 0; i < 32; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      @(negedge clk);
      chk("R1", 32'(ci_o), 0, "reset ci");
      chk("R1", acc_o, 0, "reset acc");
      chk("R1", 32'(halted_o), 1, "reset halted");
      chk("R1", 32'(halt_cause_o), 0, "reset cause");

      cur_req = "R13";
      for (int i = 0; i < 32; i++) dep(i, 32'h0100_0000 + 32'(i));
      mem_ok = 1'b1;
      // R2 R5 R7 R6 R9 R12: straight-line arithmetic with junk bits
      dep(1, ins(2, 20, 32'h8000_0100));
      dep(2, ins(4, 21, 32'h0001_0000));
      dep(3, ins(5, 22, 32'h0000_0f00));
      dep(4, ins(3, 23, 32'h0));
      dep(5, ins(7, 0, 32'h0));
      dep(20, 32'd5); dep(21, 32'd3); dep(22, 32'hFFFF_FFF6);
      cur_req = "R12"; go_run();
      chk("R9", 32'(ci_o), 5, "stop ci");
      chk("R7", acc_o, 32'd2, "acc after subtracts");
      chk("R9", 32'(halt_cause_o), 1, "stop cause");
      peek("R6", 23, 32'd2);

      // R8: skip not taken then taken; address field junk
      cur_req = "R8";
      dep(6, ins(6, 17, 32'h0));
      dep(7, ins(7, 0, 32'h0));
      dep(8, ins(2, 20, 32'h0));
      dep(9, ins(6, 31, 32'h4000_0000));
      dep(10, ins(7, 0, 32'h0));
      dep(11, ins(7, 0, 32'h0));
      go_run();
      chk("R8", 32'(ci_o), 7, "skip not taken");
      go_run();
      chk("R8", 32'(ci_o), 11, "skip taken");
      chk("R5", acc_o, 32'hFFFF_FFFB, "negated load");

      // R3 R4: absolute jump, wrapping relative jump
      cur_req = "R3";
      dep(12, ins(0, 24, 32'h0));
      dep(24, 32'hABCD_E0F1);
      dep(18, ins(7, 0, 32'h0));
      dep(19, ins(1, 25, 32'h0));
      dep(25, 32'd62);
      go_run();
      chk("R3", 32'(ci_o), 18, "absolute jump");
      cur_req = "R4";
      go_run();
      chk("R4", 32'(ci_o), 18, "relative jump wrap");

      // R10: breakpoint then resume past it
      cur_req = "R10";
      bkpt_addr_i = 5'd17; bkpt_en_i = 1'b1;
      go_run();
      chk("R10", 32'(ci_o), 17, "bkpt ci");
      chk("R10", 32'(halt_cause_o), 2, "bkpt cause");
      go_run();
      chk("R10", 32'(ci_o), 18, "resume past bkpt");
      bkpt_en_i = 1'b0;

      // R11: single steps
      cur_req = "R11";
      go_step();
      chk("R11", 32'(ci_o), 17, "step ci");
      chk("R11", 32'(halt_cause_o), 3, "step cause");
      step_i = 1'b1; run_i = 1'b1; @(negedge clk); step_i = 1'b0; run_i = 1'b0;
      @(negedge clk);
      chk("R11", 32'(halted_o), 1, "step wins over run");
      chk("R11", 32'(halt_cause_o), 1, "step onto halt");

      // R13: writes ignored while running in a tight loop
      cur_req = "R13";
      dep(18, ins(0, 28, 32'h0));
      dep(28, 32'd25);
      dep(26, ins(1, 27, 32'h0));
      dep(27, 32'd31);
      run_i = 1'b1; @(negedge clk); run_i = 1'b0;
      repeat (4) @(negedge clk);
      dbg_we_i = 1'b1; dbg_addr_i = 5'd30; dbg_wdata_i = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      dbg_we_i = 1'b0;
      chk("R12", 32'(halted_o), 0, "still running");
      bkpt_addr_i = 5'd25; bkpt_en_i = 1'b1;
      wait_halt();
      bkpt_en_i = 1'b0;
      chk("R10", 32'(ci_o), 25, "loop stopped");
      peek("R13", 30, 32'h0100_001E);
      dep(30, 32'h1234_5678);
      peek("R13", 30, 32'h1234_5678);

      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      total++; bad++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule